// File: doc/BRIEF.md
# DMA Bus Access Sequencer

This block drives the bus side of a single DMA channel. Once a transfer request has been latched, it raises a request for the internal bus. It waits for the bus controller to grant that request. For each granted beat it then performs one transfer: a read cycle at the source address, followed by a write cycle at the destination address. The element size is byte, halfword or word. The address actually used on the bus is forced to the natural alignment of that size. The address as programmed, possibly misaligned, is shown unchanged on a separate debug address output. The read element is moved from its source byte lanes to its destination byte lanes, and a byte-lane write strobe marks the lanes that the write touches.

A non-maskable interrupt input and a priority comparison let urgent interrupt service take the bus back. The comparison fires when the pending interrupt level is strictly above a programmable hold threshold. When either condition is present at a transfer boundary, the sequencer drops its bus request and parks in a pause. It remembers that work is still outstanding. When the condition goes away it raises the request again and continues once a new grant arrives. A read is never separated from its write by a pause.

The transfer counter lives outside the block. It tells the sequencer through a "last transfer" input that the current transfer is the final one. Address stepping and arbitration between channels are also handled elsewhere.

Top module: `dma_bus_seq`

## Requirements
- R1: After reset, bus_req_o, mem_rd_o, mem_wr_o and done_o are all 0.
- R2: A one-cycle pulse on req_i while the sequencer is idle raises bus_req_o on the next cycle. No read or write occurs while bus_gnt_i stays 0.
- R3: With bus_req_o high, no override present and bus_gnt_i high, the next cycle is a read cycle (mem_rd_o=1). The cycle after that is always the write cycle (mem_wr_o=1) of the same transfer.
- R4: size_i encodes 0 as byte, 1 as halfword, 2 as word, and 3 as word. mem_addr_o equals the programmed address for byte. For halfword, bit 0 is cleared. For word, bits 1:0 are cleared.
- R5: dbg_addr_o shows src_addr_i unmodified during a read cycle and dst_addr_i unmodified during a write cycle.
- R6: mem_be_o has bit k for byte lane k, where k is mem_addr_o[1:0]. For a byte it is 0001, 0010, 0100 or 1000 by that offset. For a halfword it is 0011 at offset 0 and 1100 at offset 2. For a word it is 1111.
- R7: During a write cycle, the enabled lanes of mem_wdata_o carry the element read in the preceding read cycle from the aligned source offset, moved to the aligned destination offset.
- R8: The override is nmi_i=1, or irq_lvl_i greater than hold_thr_i as unsigned 5-bit values (equal does not override). An override seen in the write cycle of a non-final transfer, or while waiting for a grant, makes bus_req_o 0 on the next cycle.
- R9: While paused, bus_req_o stays 0 and the outstanding request is kept. In the cycle after the override clears, bus_req_o returns to 1. Every requested transfer still completes once the grant is given.
- R10: An override that appears during a read cycle does not stop the write cycle that follows it.
- R11: last_i is sampled in the write cycle. If it is 1, done_o is 1 on the next cycle for exactly one cycle and bus_req_o is 0. This takes priority over an override.
- R12: After a non-final write with no override, the next transfer's read starts in the next cycle if bus_gnt_i is 1. Otherwise bus_req_o stays 1 with no access until the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Latched transfer request, pulse to start |
| size_i | input | 2 | Element size code |
| src_addr_i | input | ADDR_W | Programmed source address |
| dst_addr_i | input | ADDR_W | Programmed destination address |
| last_i | input | 1 | Current transfer is the final one |
| nmi_i | input | 1 | Non-maskable interrupt pending |
| irq_lvl_i | input | LVL_W | Level of the pending interrupt |
| hold_thr_i | input | LVL_W | Hold-override threshold |
| bus_gnt_i | input | 1 | Bus grant from the bus controller |
| bus_req_o | output | 1 | Bus request to the bus controller |
| mem_rd_o | output | 1 | Read cycle strobe |
| mem_wr_o | output | 1 | Write cycle strobe |
| mem_addr_o | output | ADDR_W | Aligned access address |
| mem_be_o | output | DATA_W/8 | Byte-lane write strobe |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid in the read cycle |
| dbg_addr_o | output | ADDR_W | Unmodified programmed address of the current access |
| done_o | output | 1 | Final transfer finished |

## Verification
Three pairs of events can fall in the same cycle, and each needs a defined winner. An override can arrive in the same cycle as the last-transfer flag. An override can arrive during a read cycle instead of at a boundary. A grant can drop on the same edge that a write closes. The bench provokes each collision by watching for the read or write strobe and raising the non-maskable input, the priority level or the grant change on that exact cycle. The priority level is also set equal to the threshold to probe the boundary. A behavioural model, advanced on every edge, predicts request, strobes, addresses, lanes and data. It judges the outcome by requiring the final transfer to win over an override, the started write to complete, and the request to fall or hold exactly one cycle later.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WRSV = 2'd3
   } xfer_size_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_RD    = 3'd2,
      ST_WR    = 3'd3,
      ST_PAUSE = 3'd4
   } seq_state_e;

endpackage

// File: rtl/dma_addr_align.sv
module dma_addr_align
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic [ADDR_W-1:0]        addr_i,
   input  xfer_size_e               size_i,
   output logic [ADDR_W-1:0]        aligned_o,
   output logic [LANES-1:0]         be_o,
   output logic [$clog2(LANES)-1:0] off_o
);
   localparam int OFF_W = $clog2(LANES);

   initial begin
      assert (LANES == 4) else $error("dma_addr_align: LANES must be 4");
      assert (ADDR_W > OFF_W) else $error("dma_addr_align: ADDR_W too small");
   end

   always_comb begin
      unique case (size_i)
         SZ_BYTE: aligned_o = addr_i;
         SZ_HALF: aligned_o = {addr_i[ADDR_W-1:1], 1'b0};
         default: aligned_o = {addr_i[ADDR_W-1:2], 2'b00};
      endcase
      off_o = aligned_o[OFF_W-1:0];
      unique case (size_i)
         SZ_BYTE: be_o = LANES'(1) << off_o;
         SZ_HALF: be_o = LANES'(3) << off_o;
         default: be_o = '1;
      endcase
   end

endmodule

// File: rtl/dma_lane_move.sv
module dma_lane_move #(
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_i,
   input  logic [DATA_W-1:0]             rdata_i,
   input  logic [$clog2(DATA_W/8)-1:0]   src_off_i,
   input  logic [$clog2(DATA_W/8)-1:0]   dst_off_i,
   output logic [DATA_W-1:0]             wdata_o
);
   localparam int OFF_W = $clog2(DATA_W/8);

   logic [DATA_W-1:0] elem_q;

   initial begin
      assert (DATA_W % 8 == 0) else $error("dma_lane_move: DATA_W must be whole bytes");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         elem_q <= '0;
      else if (cap_i)
         elem_q <= rdata_i >> {src_off_i, 3'b000};
   end

   assign wdata_o = elem_q << {dst_off_i, 3'b000};

endmodule

// File: rtl/dma_hold_ovr.sv
module dma_hold_ovr #(
   parameter int LVL_W = 5,
   parameter bit SYNC  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0] thr_i,
   output logic             ovr_o
);
   logic raw;

   initial begin
      assert (LVL_W >= 1) else $error("dma_hold_ovr: LVL_W must be positive");
   end

   assign raw = nmi_i | (lvl_i > thr_i);

   generate
      if (SYNC) begin : g_sync
         logic ovr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ovr_q <= 1'b0;
            else        ovr_q <= raw;
         end
         assign ovr_o = ovr_q;
      end else begin : g_comb
         assign ovr_o = raw;
      end
   endgenerate

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic gnt_i,
   input  logic ovr_i,
   input  logic last_i,
   output logic bus_req_o,
   output logic rd_o,
   output logic wr_o,
   output logic done_o
);
   seq_state_e state_q, state_d;
   logic       done_q, done_d;

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      unique case (state_q)
         ST_IDLE:  if (req_i) state_d = ST_REQ;
         ST_REQ: begin
            if (ovr_i)      state_d = ST_PAUSE;
            else if (gnt_i) state_d = ST_RD;
         end
         ST_RD:    state_d = ST_WR;
         ST_WR: begin
            if (last_i) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end else if (ovr_i) state_d = ST_PAUSE;
            else if (gnt_i)     state_d = ST_RD;
            else                state_d = ST_REQ;
         end
         ST_PAUSE: if (!ovr_i) state_d = ST_REQ;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
      end
   end

   assign bus_req_o = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
   assign rd_o      = (state_q == ST_RD);
   assign wr_o      = (state_q == ST_WR);
   assign done_o    = done_q;

   // R9: leaving a pause restores the request one cycle after the override clears
   p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAUSE && !ovr_i) |=> bus_req_o);

   // R2: an idle request pulse raises the bus request next cycle
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && req_i) |=> (bus_req_o && !rd_o && !wr_o));

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int LVL_W    = 5,
   parameter bit SYNC_OVR = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_i,
   input  logic [1:0]            size_i,
   input  logic [ADDR_W-1:0]     src_addr_i,
   input  logic [ADDR_W-1:0]     dst_addr_i,
   input  logic                  last_i,
   input  logic                  nmi_i,
   input  logic [LVL_W-1:0]      irq_lvl_i,
   input  logic [LVL_W-1:0]      hold_thr_i,
   input  logic                  bus_gnt_i,
   output logic                  bus_req_o,
   output logic                  mem_rd_o,
   output logic                  mem_wr_o,
   output logic [ADDR_W-1:0]     mem_addr_o,
   output logic [DATA_W/8-1:0]   mem_be_o,
   output logic [DATA_W-1:0]     mem_wdata_o,
   input  logic [DATA_W-1:0]     mem_rdata_i,
   output logic [ADDR_W-1:0]     dbg_addr_o,
   output logic                  done_o
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int NPORT = 2;

   initial begin
      assert (DATA_W == 32) else $error("dma_bus_seq: word width must be 32");
      assert (ADDR_W >= 8)  else $error("dma_bus_seq: ADDR_W too small");
   end

   xfer_size_e        size;
   logic              ovr;
   logic [ADDR_W-1:0] raw_addr [NPORT];
   logic [ADDR_W-1:0] al_addr  [NPORT];
   logic [LANES-1:0]  al_be    [NPORT];
   logic [OFF_W-1:0]  al_off   [NPORT];

   assign size        = xfer_size_e'(size_i);
   assign raw_addr[0] = src_addr_i;
   assign raw_addr[1] = dst_addr_i;

   generate
      for (genvar k = 0; k < NPORT; k++) begin : g_align
         dma_addr_align #(.ADDR_W(ADDR_W), .LANES(LANES)) u_align (
            .addr_i    (raw_addr[k]),
            .size_i    (size),
            .aligned_o (al_addr[k]),
            .be_o      (al_be[k]),
            .off_o     (al_off[k])
         );
      end
   endgenerate

   dma_hold_ovr #(.LVL_W(LVL_W), .SYNC(SYNC_OVR)) u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .nmi_i (nmi_i),
      .lvl_i (irq_lvl_i),
      .thr_i (hold_thr_i),
      .ovr_o (ovr)
   );

   dma_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .gnt_i     (bus_gnt_i),
      .ovr_i     (ovr),
      .last_i    (last_i),
      .bus_req_o (bus_req_o),
      .rd_o      (mem_rd_o),
      .wr_o      (mem_wr_o),
      .done_o    (done_o)
   );

   dma_lane_move #(.DATA_W(DATA_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (mem_rd_o),
      .rdata_i   (mem_rdata_i),
      .src_off_i (al_off[0]),
      .dst_off_i (al_off[1]),
      .wdata_o   (mem_wdata_o)
   );

   always_comb begin
      if (mem_wr_o) begin
         mem_addr_o = al_addr[1];
         dbg_addr_o = dst_addr_i;
         mem_be_o   = al_be[1];
      end else begin
         mem_addr_o = al_addr[0];
         dbg_addr_o = src_addr_i;
         mem_be_o   = mem_rd_o ? al_be[0] : '0;
      end
   end

   // R4: word-sized accesses are word aligned
   p_align_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd_o || mem_wr_o) && size_i[1]) |-> (mem_addr_o[1:0] == 2'b00));

   // R5: the programmed source address is shown unmodified during a read
   p_dbg_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> (dbg_addr_o == src_addr_i));

   // R6: a byte access enables exactly one lane
   p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd_o || mem_wr_o) && size_i == 2'd0) |-> ($countones(mem_be_o) == 1));

   // R8: override at a non-final boundary withdraws the request
   p_ovr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && !last_i && ovr) |=> !bus_req_o);

   // R10: every write is preceded by its read
   p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> $past(mem_rd_o));

   // R11: the final write is followed by completion and release
   p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && last_i) |=> (done_o && !bus_req_o));

   // R3: no access without a raised request
   p_access_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || mem_wr_o) |-> bus_req_o);

endmodule

// File: tb/dma_bus_seq_bench.sv
`timescale 1ns/1ps
module dma_bus_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [1:0]  size_i = 2'd0;
   logic [31:0] src_addr_i = '0;
   logic [31:0] dst_addr_i = '0;
   logic        last_i;
   logic        nmi_i = 1'b0;
   logic [4:0]  irq_lvl_i = 5'd0;
   logic [4:0]  hold_thr_i = 5'd31;
   logic        bus_gnt_i = 1'b1;
   logic        bus_req_o, mem_rd_o, mem_wr_o, done_o;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, dbg_addr_o;
   logic [3:0]  mem_be_o;

   int checks = 0;
   int errors = 0;
   int wrs = 0;
   int target = 1;
   logic run_start = 1'b0;
   logic [31:0] mem [0:63];

   always #2 clk = ~clk;

   dma_bus_seq u_dma_bus_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .size_i(size_i),
      .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .last_i(last_i),
      .nmi_i(nmi_i), .irq_lvl_i(irq_lvl_i), .hold_thr_i(hold_thr_i),
      .bus_gnt_i(bus_gnt_i), .bus_req_o(bus_req_o), .mem_rd_o(mem_rd_o),
      .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .dbg_addr_o(dbg_addr_o), .done_o(done_o)
   );

   assign mem_rdata_i = mem[mem_addr_o[7:2]];
   assign last_i = (wrs == target - 1);

   function automatic logic [31:0] align(input logic [31:0] a, input logic [1:0] sz);
      if (sz == 2'd0) return a;
      if (sz == 2'd1) return a & ~32'd1;
      return a & ~32'd3;
   endfunction

   function automatic logic [3:0] lanes(input logic [31:0] a, input logic [1:0] sz);
      int o = int'(align(a, sz) & 32'd3);
      if (sz == 2'd0) return 4'b0001 << o;
      if (sz == 2'd1) return (o == 0) ? 4'b0011 : 4'b1100;
      return 4'b1111;
   endfunction

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m = '0;
      for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
      return m;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 idle, 1 waiting, 2 read, 3 write, 4 paused
   int          ph = 0;
   logic        done_m = 1'b0;
   logic [31:0] wexp = '0;

   function automatic logic ovr_m();
      return nmi_i || (int'(irq_lvl_i) > int'(hold_thr_i));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; done_m = 1'b0;
      end else begin
         done_m = 1'b0;
         case (ph)
            0: if (req_i) ph = 1;
            1: if (ovr_m()) ph = 4; else if (bus_gnt_i) ph = 2;
            2: begin
               wexp = (mem[align(src_addr_i, size_i) >> 2] >> (8 * (align(src_addr_i, size_i) & 3)))
                      << (8 * (align(dst_addr_i, size_i) & 3));
               ph = 3;
            end
            3: if (last_i) begin ph = 0; done_m = 1'b1; end
               else if (ovr_m()) ph = 4;
               else if (bus_gnt_i) ph = 2;
               else ph = 1;
            4: if (!ovr_m()) ph = 1;
            default: ph = 0;
         endcase
      end
   end

   // bench-side memory and write counter
   always @(posedge clk) begin
      if (mem_wr_o)
         for (int i = 0; i < 4; i++)
            if (mem_be_o[i]) mem[mem_addr_o[7:2]][8*i +: 8] <= mem_wdata_o[8*i +: 8];
      if (run_start) wrs <= 0;
      else if (mem_wr_o) wrs <= wrs + 1;
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8", "bus_req", 32'(bus_req_o), 32'(ph == 1 || ph == 2 || ph == 3));
         chk("R3", "rd", 32'(mem_rd_o), 32'(ph == 2));
         chk("R3", "wr", 32'(mem_wr_o), 32'(ph == 3));
         chk("R11", "done", 32'(done_o), 32'(done_m));
         if (ph == 2) begin
            chk("R4", "rd addr", mem_addr_o, align(src_addr_i, size_i));
            chk("R5", "rd dbg", dbg_addr_o, src_addr_i);
            chk("R6", "rd be", 32'(mem_be_o), 32'(lanes(src_addr_i, size_i)));
         end
         if (ph == 3) begin
            chk("R4", "wr addr", mem_addr_o, align(dst_addr_i, size_i));
            chk("R5", "wr dbg", dbg_addr_o, dst_addr_i);
            chk("R6", "wr be", 32'(mem_be_o), 32'(lanes(dst_addr_i, size_i)));
            chk("R7", "wdata", mem_wdata_o & lane_mask(mem_be_o), wexp & lane_mask(mem_be_o));
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic start(input logic [1:0] sz, input logic [31:0] s, input logic [31:0] d, input int n);
      tick();
      size_i = sz; src_addr_i = s; dst_addr_i = d; target = n;
      req_i = 1'b1; run_start = 1'b1;
      tick();
      req_i = 1'b0; run_start = 1'b0;
   endtask

   task automatic wait_strobe(input bit want_wr);
      for (int i = 0; i < 200; i++) begin
         if (want_wr ? mem_wr_o : mem_rd_o) return;
         tick();
      end
      chk("R3", "strobe timeout", 32'd0, 32'd1);
   endtask

   task automatic finish_run(input int n);
      bit seen = 1'b0;
      for (int i = 0; i < 500 && !seen; i++) begin
         tick();
         if (done_o) seen = 1'b1;
      end
      chk("R11", "done seen", 32'(seen), 32'd1);
      chk("R9", "transfers completed", 32'(wrs), 32'(n));
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F96;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "bus_req at reset", 32'(bus_req_o), 32'd0);
      chk("R1", "strobes at reset", 32'({mem_rd_o, mem_wr_o, done_o}), 32'd0);
      rst_n = 1'b1;
      tick();
      chk("R1", "idle after reset", 32'(bus_req_o), 32'd0);

      // byte transfers, back-to-back under a held grant
      start(2'd0, 32'h11, 32'h22, 3);
      chk("R2", "request raised", 32'(bus_req_o), 32'd1);
      wait_strobe(1'b0);
      tick();
      chk("R3", "write follows read", 32'(mem_wr_o), 32'd1);
      tick();
      chk("R12", "back-to-back read", 32'(mem_rd_o), 32'd1);
      finish_run(3);

      // grant withheld, misaligned halfword
      bus_gnt_i = 1'b0;
      start(2'd1, 32'h13, 32'h26, 2);
      repeat (3) tick();
      chk("R2", "no access without grant", 32'({mem_rd_o, mem_wr_o}), 32'd0);
      chk("R2", "request held", 32'(bus_req_o), 32'd1);
      bus_gnt_i = 1'b1;
      finish_run(2);

      // NMI at a write boundary, misaligned word
      start(2'd2, 32'h2B, 32'h35, 4);
      wait_strobe(1'b1);
      nmi_i = 1'b1;
      tick();
      chk("R8", "request dropped on nmi", 32'(bus_req_o), 32'd0);
      repeat (2) tick();
      chk("R9", "paused stays released", 32'(bus_req_o), 32'd0);
      nmi_i = 1'b0;
      tick();
      chk("R9", "request restored", 32'(bus_req_o), 32'd1);
      finish_run(4);

      // level compare: equal does not override, greater does; size code 3 acts as word
      hold_thr_i = 5'd10;
      irq_lvl_i  = 5'd10;
      start(2'd3, 32'h42, 32'h57, 3);
      wait_strobe(1'b1);
      tick();
      chk("R8", "equal level no pause", 32'(bus_req_o), 32'd1);
      wait_strobe(1'b1);
      irq_lvl_i = 5'd11;
      tick();
      chk("R8", "higher level pauses", 32'(bus_req_o), 32'd0);
      irq_lvl_i = 5'd0;
      finish_run(3);
      hold_thr_i = 5'd31;

      // override during a read cycle
      start(2'd0, 32'h63, 32'h70, 3);
      wait_strobe(1'b0);
      nmi_i = 1'b1;
      tick();
      chk("R10", "write completes under nmi", 32'(mem_wr_o), 32'd1);
      tick();
      chk("R10", "pause after write", 32'(bus_req_o), 32'd0);
      nmi_i = 1'b0;
      finish_run(3);

      // grant drops as a write closes
      start(2'd1, 32'h84, 32'h92, 3);
      wait_strobe(1'b1);
      bus_gnt_i = 1'b0;
      tick();
      chk("R12", "wait without grant", 32'({bus_req_o, mem_rd_o}), 32'b10);
      tick();
      bus_gnt_i = 1'b1;
      finish_run(3);

      // final transfer wins over an override
      start(2'd2, 32'hA0, 32'hB4, 1);
      wait_strobe(1'b1);
      nmi_i = 1'b1;
      tick();
      chk("R11", "done beats override", 32'({done_o, bus_req_o}), 32'b10);
      nmi_i = 1'b0;
      tick();
      chk("R11", "done single cycle", 32'(done_o), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule